// File: doc/BRIEF.md
# SPI EEPROM Status and Write-Protect Controller

This block owns the status byte of a small serial EEPROM and decides whether a write-type command may start. It receives one-cycle strobes from an instruction decoder that sits upstream: write-enable set, write-enable clear, status read, status write and array write. It also receives the status-write data byte, the array address of a pending write, the write-protect pin level and a lock-enable flag. It answers with the status byte, a one-cycle accept pulse for array writes, and a busy flag.

The write-enable latch arms the part for one write. It is dropped again by a number of separate events. The two block-protect bits mark a top slice of the array as read-only. They are held in non-reset storage, so a supply reset leaves them unchanged. A built-in cycle counter stands in for the write engine. It sets how long the busy flag stays high, and its final cycle is the point where the write completes.

Top module: `eeprom_status_guard`

## Requirements
- R1: `status_byte` reads {4'b1111, bp[1:0], wel, wip}: bits 7..4 are always 1, bit 3 is BP1, bit 2 is BP0, bit 1 is the write-enable latch and bit 0 is the busy flag.
- R2: Only `cmd_wren` sets WEL. It does so only while not busy and while `wp_n` is high.
- R3: While WEL is 0, `cmd_write` and `cmd_wrsr` change nothing: no accept pulse, no busy and no BP change.
- R4: WEL is cleared by `rst_n` low, by `cmd_wrdi` while idle, by any cycle in which `wp_n` is low, and by the completion of a status write or an array write.
- R5: The BP bits change only when an accepted status write completes. They take bits 3:2 of `wrsr_data`, and all other data bits are discarded.
- R6: If `wp_n` is low and `lock_en` is high in the cycle a status write is accepted, the BP bits keep their value. If `lock_en` is low, `wp_n` has no effect on the BP update.
- R7: The protected range is set by BP: 00 protects nothing, 01 protects addresses whose top two bits are 11, 10 protects addresses whose top bit is 1, and 11 protects every address. A write to a protected address is dropped without an accept pulse or busy.
- R8: An accepted array write raises `write_accept` for exactly one cycle, in the cycle after the command. `wip` is high for WRITE_CYCLES cycles from that same cycle, and then drops together with WEL.
- R9: While `wip` is 1, every command is ignored. `cmd_rdsr` never changes state.
- R10: After `rst_n` low, WEL and WIP read 0 and the BP bits keep their earlier value.

Parameters: ADDR_W (default 7), WRITE_CYCLES (default 4), BP_INIT (default 2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on / brown-out reset |
| cmd_wren | input | 1 | Write-enable set strobe |
| cmd_wrdi | input | 1 | Write-enable clear strobe |
| cmd_rdsr | input | 1 | Status read strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| cmd_write | input | 1 | Array write strobe |
| wrsr_data | input | 8 | Data byte for a status write |
| wr_addr | input | ADDR_W | Target address of an array write |
| wp_n | input | 1 | Write-protect pin level, low means protect |
| lock_en | input | 1 | Nonvolatile flag that lets a low `wp_n` freeze BP |
| status_byte | output | 8 | Status byte for readout |
| write_accept | output | 1 | One-cycle pulse for an accepted array write |
| wip | output | 1 | Write cycle in progress |

## Verification
Each protect level is tested with addresses on both sides of its boundary, such as 0x5F against 0x60 and 0x3F against 0x40. These pairs show whether the decoder compares the right upper address bits. Status writes carry data whose bits outside 3:2 differ from the bits inside, which shows whether only the right field is stored. A status write with `wp_n` low is run once with `lock_en` set and once with it clear, which separates the hardware lock from the plain clearing of WEL. Commands sent while busy, while WEL is clear and around reset show the different ways WEL is dropped and show that the BP bits are kept.

// File: rtl/esg_pkg.sv
// Package: shared types for the EEPROM status guard.
// Assumes the BP field is two bits wide, as the status byte layout demands.
package esg_pkg;

    // Size of the protected slice at the top of the array
    typedef enum logic [1:0] {
        PROT_NONE    = 2'b00,
        PROT_QUARTER = 2'b01,
        PROT_HALF    = 2'b10,
        PROT_ALL     = 2'b11
    } prot_mode_e;

    localparam logic [3:0] STATUS_FILL = 4'b1111;

endpackage

// File: rtl/esg_protect_map.sv
// Module: esg_protect_map
// Decides whether an address falls in the slice that the BP mode protects.
// Assumes ADDR_W >= 2. Purely combinational.
module esg_protect_map
    import esg_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  prot_mode_e          mode,
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit
);
    localparam int TOP = ADDR_W - 1;

    // Compare the upper address bits against the selected slice
    always_comb begin
        unique case (mode)
            PROT_NONE:    hit = 1'b0;
            PROT_QUARTER: hit = addr[TOP] & addr[TOP-1];
            PROT_HALF:    hit = addr[TOP];
            PROT_ALL:     hit = 1'b1;
            default:      hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/esg_write_timer.sv
// Module: esg_write_timer
// Stand-in for the memory write engine: after start it stays busy for
// CYCLES clock cycles and pulses done during the last one.
// Assumes start only arrives while idle. Synchronous active-low reset.
module esg_write_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Count remaining cycles of the write
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= LOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - LAST;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == LAST);

    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);                                             // R8
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !busy);                                // R8
endmodule

// File: rtl/esg_bp_store.sv
// Module: esg_bp_store
// Holds the two block-protect bits. Models nonvolatile storage: no reset
// input, the power-up value comes from INIT, and only load changes it.
module esg_bp_store #(
    parameter logic [1:0] INIT = 2'b00
) (
    input  logic       clk,
    input  logic       load,
    input  logic [1:0] load_val,
    output logic [1:0] bp
);
    logic [1:0] bp_q = INIT;

    // Take a new BP value when the status write completes
    always_ff @(posedge clk) begin
        if (load)
            bp_q <= load_val;
    end

    assign bp = bp_q;
endmodule

// File: rtl/eeprom_status_guard.sv
// Module: eeprom_status_guard (top)
// Keeps the status byte of a serial EEPROM and gates write-type commands.
// Assumes: command strobes are single-cycle and at most one is high per
// cycle; rst_n is the synchronous power-on / brown-out reset.
module eeprom_status_guard
    import esg_pkg::*;
#(
    parameter int         ADDR_W       = 7,
    parameter int         WRITE_CYCLES = 4,
    parameter logic [1:0] BP_INIT      = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_rdsr,
    input  logic              cmd_wrsr,
    input  logic              cmd_write,
    input  logic [7:0]        wrsr_data,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wp_n,
    input  logic              lock_en,
    output logic [7:0]        status_byte,
    output logic              write_accept,
    output logic              wip
);
    logic       wel_q;
    logic       accept_q;
    logic       pend_sr_q;
    logic [1:0] pend_bp_q;
    logic [1:0] bp;
    logic       prot_hit;
    logic       eng_busy;
    logic       eng_done;
    logic       idle;
    logic       hw_lock;
    logic       acc_write;
    logic       acc_wrsr;
    logic       start;
    logic       rdsr_seen;

    // Status read needs no state change; it is only decoded here
    assign rdsr_seen = cmd_rdsr;

    esg_protect_map #(.ADDR_W(ADDR_W)) u_map (
        .mode (prot_mode_e'(bp)),
        .addr (wr_addr),
        .hit  (prot_hit)
    );

    esg_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (eng_busy),
        .done  (eng_done)
    );

    esg_bp_store #(.INIT(BP_INIT)) u_bp (
        .clk      (clk),
        .load     (eng_done && pend_sr_q && rst_n),
        .load_val (pend_bp_q),
        .bp       (bp)
    );

    // Command qualification
    assign idle      = !eng_busy;
    assign hw_lock   = !wp_n && lock_en;
    assign acc_write = idle && wel_q && cmd_write && !prot_hit;
    assign acc_wrsr  = idle && wel_q && cmd_wrsr && !rdsr_seen;
    assign start     = acc_write || acc_wrsr;

    // Write-enable latch: clear events take priority over a set
    always_ff @(posedge clk) begin
        if (!rst_n)
            wel_q <= 1'b0;
        else if (!wp_n || eng_done)
            wel_q <= 1'b0;
        else if (idle && cmd_wrdi)
            wel_q <= 1'b0;
        else if (idle && cmd_wren)
            wel_q <= 1'b1;
    end

    // One-cycle pulse for an accepted array write
    always_ff @(posedge clk) begin
        if (!rst_n)
            accept_q <= 1'b0;
        else
            accept_q <= acc_write;
    end

    // Capture the BP value a status write will commit on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_sr_q <= 1'b0;
            pend_bp_q <= 2'b00;
        end else if (acc_wrsr) begin
            pend_sr_q <= 1'b1;
            pend_bp_q <= hw_lock ? bp : wrsr_data[3:2];
        end else if (acc_write) begin
            pend_sr_q <= 1'b0;
        end
    end

    assign wip          = eng_busy;
    assign write_accept = accept_q;
    assign status_byte  = {STATUS_FILL, bp, wel_q, eng_busy};

    AST_WEL_SET_BY_WREN: assert property (@(posedge clk) disable iff (!rst_n)
        (wel_q && !$past(wel_q)) |-> $past(cmd_wren));              // R2
    AST_WP_LOW_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |=> !wel_q);                                          // R4
    AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && !$past(wip)) |-> $past(wel_q));                     // R3
    AST_BP_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !wip |=> $stable(bp));                                      // R5
    AST_ACCEPT_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        write_accept |-> (wip && !$past(wip)));                     // R8
    AST_RESET_KEEPS_BP: assert property (@(posedge clk)
        !rst_n |=> $stable(bp));                                    // R10
    AST_BUSY_IGNORES_WREN: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && !wel_q) |=> !wel_q);                                // R9
endmodule

// File: tb/eeprom_status_guard_tb.sv
module eeprom_status_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 7;

    typedef struct {
        logic [7:0] exp_status;
        logic       exp_acc;
        string      req;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wren = 0, cmd_wrdi = 0, cmd_rdsr = 0, cmd_wrsr = 0, cmd_write = 0;
    logic [7:0]    wrsr_data = '0;
    logic [AW-1:0] wr_addr = '0;
    logic          wp_n = 1'b1;
    logic          lock_en = 1'b0;
    logic [7:0]    status_byte;
    logic          write_accept;
    logic          wip;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_status_guard #(.ADDR_W(AW), .WRITE_CYCLES(4), .BP_INIT(2'b00)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_rdsr(cmd_rdsr),
        .cmd_wrsr(cmd_wrsr), .cmd_write(cmd_write),
        .wrsr_data(wrsr_data), .wr_addr(wr_addr),
        .wp_n(wp_n), .lock_en(lock_en),
        .status_byte(status_byte), .write_accept(write_accept), .wip(wip)
    );

    // Monitor: compare outputs against the oldest expectation
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (status_byte !== it.exp_status || write_accept !== it.exp_acc) begin
                errors++;
                $display("FAIL %s: status=%h accept=%b expected status=%h accept=%b",
                         it.req, status_byte, write_accept, it.exp_status, it.exp_acc);
            end
        end
    end

    // Driver: apply one command for one clock edge, then queue the expectation
    task automatic op(input string kind, input logic [7:0] data, input logic [AW-1:0] addr,
                      input logic [7:0] exp, input logic acc, input string req);
        @(negedge clk);
        wrsr_data = data;
        wr_addr   = addr;
        cmd_wren  = (kind == "wren");
        cmd_wrdi  = (kind == "wrdi");
        cmd_rdsr  = (kind == "rdsr");
        cmd_wrsr  = (kind == "wrsr");
        cmd_write = (kind == "write");
        rst_n     = (kind != "reset");
        @(posedge clk);
        #1;
        cmd_wren = 0; cmd_wrdi = 0; cmd_rdsr = 0; cmd_wrsr = 0; cmd_write = 0;
        rst_n = 1'b1;
        q.push_back('{exp, acc, req});
    endtask

    task automatic idle(input logic [7:0] exp, input string req);
        op("idle", 8'h00, '0, exp, 1'b0, req);
    endtask

    // Three busy cycles at `busy`, then the cycle where the write ends at `fin`
    task automatic finish_write(input logic [7:0] busy, input logic [7:0] fin, input string req);
        for (int i = 0; i < 3; i++) idle(busy, req);
        idle(fin, req);
    endtask

    initial begin
        op("reset", 8'h00, '0, 8'hF0, 1'b0, "R1 R10 reset state");
        op("reset", 8'h00, '0, 8'hF0, 1'b0, "R10 reset state");
        op("write", 8'h00, 7'h00, 8'hF0, 1'b0, "R3 write without WEL");
        op("wrsr", 8'hFF, '0, 8'hF0, 1'b0, "R3 wrsr without WEL");
        op("wren", 8'h00, '0, 8'hF2, 1'b0, "R2 wren sets WEL");
        op("rdsr", 8'h00, '0, 8'hF2, 1'b0, "R9 rdsr no effect");
        op("wrdi", 8'h00, '0, 8'hF0, 1'b0, "R4 wrdi clears WEL");
        op("wren", 8'h00, '0, 8'hF2, 1'b0, "R2 wren");
        op("write", 8'h00, 7'h00, 8'hF3, 1'b1, "R8 accepted write");
        finish_write(8'hF3, 8'hF0, "R8 R4 write cycle");
        op("wren", 8'h00, '0, 8'hF2, 1'b0, "R2 wren");
        op("write", 8'h00, 7'h7F, 8'hF3, 1'b1, "R8 write top address bp=00");
        op("wrdi", 8'h00, '0, 8'hF3, 1'b0, "R9 wrdi ignored while busy");
        op("wrsr", 8'hFC, '0, 8'hF3, 1'b0, "R9 wrsr ignored while busy");
        idle(8'hF3, "R8 busy");
        idle(8'hF0, "R8 R4 completion clears WEL");
        op("wren", 8'h00, '0, 8'hF2, 1'b0, "R2 wren");
        op("wrsr", 8'hF5, '0, 8'hF3, 1'b0, "R5 wrsr accepted");
        finish_write(8'hF3, 8'hF4, "R5 bp=01 from data bits 3:2");
        op("wren", 8'h00, '0, 8'hF6, 1'b0, "R2 wren");
        op("write", 8'h00, 7'h60, 8'hF6, 1'b0, "R7 quarter protect 0x60 dropped");
        op("write", 8'h00, 7'h5F, 8'hF7, 1'b1, "R7 quarter protect 0x5F allowed");
        finish_write(8'hF7, 8'hF4, "R8 write cycle");
        op("wren", 8'h00, '0, 8'hF6, 1'b0, "R2 wren");
        op("wrsr", 8'h08, '0, 8'hF7, 1'b0, "R5 wrsr");
        finish_write(8'hF7, 8'hF8, "R5 bp=10");
        op("wren", 8'h00, '0, 8'hFA, 1'b0, "R2 wren");
        op("write", 8'h00, 7'h40, 8'hFA, 1'b0, "R7 half protect 0x40 dropped");
        op("write", 8'h00, 7'h3F, 8'hFB, 1'b1, "R7 half protect 0x3F allowed");
        finish_write(8'hFB, 8'hF8, "R8 write cycle");
        op("wren", 8'h00, '0, 8'hFA, 1'b0, "R2 wren");
        wp_n = 1'b0;
        idle(8'hF8, "R4 wp low clears WEL");
        op("wren", 8'h00, '0, 8'hF8, 1'b0, "R2 wren blocked by wp low");
        wp_n = 1'b1;
        op("wren", 8'h00, '0, 8'hFA, 1'b0, "R2 wren");
        wp_n = 1'b0; lock_en = 1'b1;
        op("wrsr", 8'h0C, '0, 8'hF9, 1'b0, "R6 wrsr under lock");
        wp_n = 1'b1;
        finish_write(8'hF9, 8'hF8, "R6 bp kept under lock");
        op("wren", 8'h00, '0, 8'hFA, 1'b0, "R2 wren");
        wp_n = 1'b0; lock_en = 1'b0;
        op("wrsr", 8'h0C, '0, 8'hF9, 1'b0, "R6 wrsr with lock off");
        wp_n = 1'b1;
        finish_write(8'hF9, 8'hFC, "R6 bp=11 with lock off");
        op("wren", 8'h00, '0, 8'hFE, 1'b0, "R2 wren");
        op("write", 8'h00, 7'h00, 8'hFE, 1'b0, "R7 full protect 0x00 dropped");
        op("reset", 8'h00, '0, 8'hFC, 1'b0, "R10 reset keeps bp, clears WEL");
        op("wren", 8'h00, '0, 8'hFE, 1'b0, "R2 wren");
        op("wrsr", 8'h00, '0, 8'hFF, 1'b0, "R5 wrsr");
        op("reset", 8'h00, '0, 8'hFC, 1'b0, "R10 reset mid-cycle clears WIP");
        idle(8'hFC, "R10 bp kept after aborted cycle");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule